// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry

This block produces the second ALU operand of a load/store RISC datapath for instructions whose shift amount is taken from a register. It takes the source operand and the shift-amount register value, applies one of four shift kinds, and returns both the shifted value and the shifter carry that feeds the flag logic. It is purely combinational, so it sits between the register-file read and the ALU input inside one cycle.

Only the low byte of the amount register counts. An amount of zero leaves the operand alone and passes the incoming carry through. Amounts equal to the data width and amounts above it each have their own results. When the source register is the program counter, the operand is read four bytes ahead before it is shifted.

Top module: `regshift_barrel`

## Requirements
- R1: `shift_kind` selects the shift: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right.
- R2: Only bits [7:0] of `amt_reg` form the shift amount; bits [31:8] have no effect on either output.
- R3: With `src_is_pc` high, the operand is `src_val + 4` (modulo 2^32) for every later rule, including pass-through; with it low, the operand is `src_val`.
- R4: An amount of 0 gives `shifted_val` equal to the operand and `carry_out` equal to `carry_in`, for all four kinds.
- R5: Logical left by n in 1..31 gives operand << n, with carry equal to operand bit 32-n.
- R6: Logical left by exactly 32 gives 0 with carry equal to operand bit 0; by more than 32 gives 0 with carry 0.
- R7: Logical right by n in 1..31 gives operand >> n (zero fill), with carry equal to operand bit n-1.
- R8: Logical right by exactly 32 gives 0 with carry equal to operand bit 31; by more than 32 gives 0 with carry 0.
- R9: Arithmetic right by n in 1..31 fills with operand bit 31, with carry equal to operand bit n-1.
- R10: Arithmetic right by 32 or more sets all 32 bits and the carry to operand bit 31.
- R11: Rotate right with m = amount mod 32 nonzero rotates by m, with carry equal to operand bit m-1.
- R12: Rotate right by a nonzero multiple of 32 returns the operand unchanged, with carry equal to operand bit 31.
- R13: The block has no clock or reset; both outputs are a pure function of the present inputs, so all-zero inputs give a value of 0 and a carry of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_val | input | 32 | Source operand as read from the register file |
| src_is_pc | input | 1 | High when the source register is the program counter |
| amt_reg | input | 32 | Shift-amount register value |
| shift_kind | input | 2 | Shift kind (see R1) |
| carry_in | input | 1 | Current carry flag |
| shifted_val | output | 32 | Shifted second ALU operand |
| carry_out | output | 1 | Shifter carry |

## Verification
Nothing is held between evaluations, so any internal fault shows at the ports in the same evaluation as the input pattern that exercises it. A broken stage of the logarithmic network corrupts `shifted_val` only for amounts that have that stage's bit set. A fault in the stage-wise carry tracking leaves the value correct and shows only on `carry_out`. A fault in amount classification shows as wrong results at exactly 0, 32 or above 32. For that reason the amounts swept include one for each stage bit and each class boundary, and every shift kind is run with the source both as an ordinary register and as the program counter.

// File: rtl/regshift_pkg.sv
package regshift_pkg;

   typedef enum logic [1:0] {
      SK_LSL = 2'b00,
      SK_LSR = 2'b01,
      SK_ASR = 2'b10,
      SK_ROR = 2'b11
   } shift_kind_e;

   typedef struct packed {
      logic is_zero;
      logic in_range;
      logic eq_width;
      logic over_width;
      logic rot_zero;
   } amt_class_t;

endpackage

// File: rtl/regshift_operand.sv
module regshift_operand #(
   parameter int DATA_W = 32,
   parameter int PC_ADJ = 4
) (
   input  logic [DATA_W-1:0] raw_val,
   input  logic              raw_is_pc,
   output logic [DATA_W-1:0] op_val
);
   localparam logic [DATA_W-1:0] ADJ_V = DATA_W'(PC_ADJ);

   assign op_val = raw_is_pc ? (raw_val + ADJ_V) : raw_val;
endmodule

// File: rtl/regshift_amt_class.sv
module regshift_amt_class
   import regshift_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8
) (
   input  logic [AMT_W-1:0] amt,
   output amt_class_t       cls
);
   localparam int SH_W = $clog2(DATA_W);
   localparam logic [AMT_W-1:0] WIDTH_V = AMT_W'(DATA_W);

   always_comb begin
      cls.is_zero    = (amt == '0);
      cls.eq_width   = (amt == WIDTH_V);
      cls.over_width = (amt > WIDTH_V);
      cls.in_range   = !cls.is_zero && (amt < WIDTH_V);
      cls.rot_zero   = (amt[SH_W-1:0] == '0);
   end
endmodule

// File: rtl/regshift_lognet.sv
module regshift_lognet #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]         din,
   input  logic [$clog2(DATA_W)-1:0] sh,
   input  logic                      fill,
   input  logic                      rotate,
   output logic [DATA_W-1:0]         dout,
   output logic                      last_out
);
   localparam int SH_W = $clog2(DATA_W);

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int STEP = 1 << s;
      logic [DATA_W-1:0] prev_q;
      logic              prev_c;
      logic [DATA_W-1:0] q;
      logic              c;

      if (s == 0) begin : g_first
         assign prev_q = din;
         assign prev_c = 1'b0;
      end else begin : g_chain
         assign prev_q = g_stage[s-1].q;
         assign prev_c = g_stage[s-1].c;
      end

      always_comb begin
         if (sh[s]) begin
            if (rotate) q = {prev_q[STEP-1:0], prev_q[DATA_W-1:STEP]};
            else        q = {{STEP{fill}}, prev_q[DATA_W-1:STEP]};
            c = prev_q[STEP-1];
         end else begin
            q = prev_q;
            c = prev_c;
         end
      end
   end

   assign dout     = g_stage[SH_W-1].q;
   assign last_out = g_stage[SH_W-1].c;
endmodule

// File: rtl/regshift_barrel.sv
module regshift_barrel
   import regshift_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int REG_W  = 32,
   parameter int AMT_W  = 8,
   parameter int PC_ADJ = 4
) (
   input  logic [DATA_W-1:0] src_val,
   input  logic              src_is_pc,
   input  logic [REG_W-1:0]  amt_reg,
   input  logic [1:0]        shift_kind,
   input  logic              carry_in,
   output logic [DATA_W-1:0] shifted_val,
   output logic              carry_out
);
   localparam int SH_W = $clog2(DATA_W);

   if ((DATA_W < 2) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_bad_width
      $error("regshift_barrel: DATA_W must be a power of two of at least 2");
   end
   if (AMT_W <= SH_W) begin : g_bad_amt
      $error("regshift_barrel: AMT_W must exceed log2(DATA_W)");
   end
   if (REG_W <= AMT_W) begin : g_bad_reg
      $error("regshift_barrel: REG_W must exceed AMT_W");
   end

   shift_kind_e       kind;
   logic [AMT_W-1:0]  amt;
   logic              amt_unused_hi;
   logic [DATA_W-1:0] op;
   logic [DATA_W-1:0] op_rev;
   logic [DATA_W-1:0] net_in;
   logic [DATA_W-1:0] net_out;
   logic [DATA_W-1:0] net_rev;
   logic              net_last;
   logic              net_fill;
   amt_class_t        cls;

   assign kind          = shift_kind_e'(shift_kind);
   assign amt           = amt_reg[AMT_W-1:0];
   assign amt_unused_hi = ^amt_reg[REG_W-1:AMT_W];

   regshift_operand #(.DATA_W(DATA_W), .PC_ADJ(PC_ADJ)) u_operand (
      .raw_val   (src_val),
      .raw_is_pc (src_is_pc),
      .op_val    (op)
   );

   regshift_amt_class #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_class (
      .amt (amt),
      .cls (cls)
   );

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign op_rev[i]  = op[DATA_W-1-i];
      assign net_rev[i] = net_out[DATA_W-1-i];
   end

   assign net_in   = (kind == SK_LSL) ? op_rev : op;
   assign net_fill = (kind == SK_ASR) ? op[DATA_W-1] : 1'b0;

   regshift_lognet #(.DATA_W(DATA_W)) u_net (
      .din      (net_in),
      .sh       (amt[SH_W-1:0]),
      .fill     (net_fill),
      .rotate   (kind == SK_ROR),
      .dout     (net_out),
      .last_out (net_last)
   );

   always_comb begin
      shifted_val = op;
      carry_out   = carry_in;
      if (!cls.is_zero) begin
         unique case (kind)
            SK_LSL: begin
               if (cls.in_range) begin
                  shifted_val = net_rev;
                  carry_out   = net_last;
               end else begin
                  shifted_val = '0;
                  carry_out   = cls.eq_width ? op[0] : 1'b0;
               end
            end
            SK_LSR: begin
               if (cls.in_range) begin
                  shifted_val = net_out;
                  carry_out   = net_last;
               end else begin
                  shifted_val = '0;
                  carry_out   = cls.eq_width ? op[DATA_W-1] : 1'b0;
               end
            end
            SK_ASR: begin
               if (cls.in_range) begin
                  shifted_val = net_out;
                  carry_out   = net_last;
               end else begin
                  shifted_val = {DATA_W{op[DATA_W-1]}};
                  carry_out   = op[DATA_W-1];
               end
            end
            SK_ROR: begin
               if (cls.rot_zero) begin
                  shifted_val = op;
                  carry_out   = op[DATA_W-1];
               end else begin
                  shifted_val = net_out;
                  carry_out   = net_out[DATA_W-1];
               end
            end
            default: begin
               shifted_val = op;
               carry_out   = carry_in;
            end
         endcase
      end
   end
endmodule

// File: rtl/regshift_barrel_chk.sv
module regshift_barrel_chk #(
   parameter int DATA_W = 32,
   parameter int REG_W  = 32,
   parameter int AMT_W  = 8,
   parameter int PC_ADJ = 4
) (
   input logic [DATA_W-1:0] src_val,
   input logic              src_is_pc,
   input logic [REG_W-1:0]  amt_reg,
   input logic [1:0]        shift_kind,
   input logic              carry_in,
   input logic [DATA_W-1:0] shifted_val,
   input logic              carry_out
);
   localparam logic [AMT_W-1:0] WIDTH_V = AMT_W'(DATA_W);

   logic [DATA_W-1:0] eff_op;
   logic [AMT_W-1:0]  eff_amt;

   assign eff_op  = src_val + (src_is_pc ? DATA_W'(PC_ADJ) : '0);
   assign eff_amt = amt_reg[AMT_W-1:0];

   always_comb begin
      if (eff_amt == '0)
         AST_ZERO_PASS: assert (shifted_val == eff_op && carry_out == carry_in); // R4
      if (shift_kind == 2'b00 && eff_amt > WIDTH_V)
         AST_LSL_OVER_CLEAR: assert (shifted_val == '0 && !carry_out); // R6
      if (shift_kind == 2'b01 && eff_amt >= WIDTH_V)
         AST_LSR_FLOOD_ZERO: assert (shifted_val == '0); // R8
      if (shift_kind == 2'b10 && eff_amt >= WIDTH_V)
         AST_ASR_SIGN_FILL: assert (($countones(shifted_val) == 0 || $countones(shifted_val) == DATA_W)
                                    && carry_out == shifted_val[0]); // R10
      if (shift_kind == 2'b11)
         AST_ROR_KEEPS_ONES: assert ($countones(shifted_val) == $countones(eff_op)); // R11
   end
endmodule

bind regshift_barrel regshift_barrel_chk #(
   .DATA_W (DATA_W),
   .REG_W  (REG_W),
   .AMT_W  (AMT_W),
   .PC_ADJ (PC_ADJ)
) chk_i (
   .src_val     (src_val),
   .src_is_pc   (src_is_pc),
   .amt_reg     (amt_reg),
   .shift_kind  (shift_kind),
   .carry_in    (carry_in),
   .shifted_val (shifted_val),
   .carry_out   (carry_out)
);

// File: tb/regshift_barrel_tb_top.sv
module regshift_barrel_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   logic        clk = 1'b0;
   logic [31:0] src_val = '0;
   logic        src_is_pc = 1'b0;
   logic [31:0] amt_reg = '0;
   logic [1:0]  shift_kind = '0;
   logic        carry_in = 1'b0;
   logic [31:0] shifted_val;
   logic        carry_out;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regshift_barrel dut_i (
      .src_val     (src_val),
      .src_is_pc   (src_is_pc),
      .amt_reg     (amt_reg),
      .shift_kind  (shift_kind),
      .carry_in    (carry_in),
      .shifted_val (shifted_val),
      .carry_out   (carry_out)
   );

   function automatic logic [32:0] ref_model(logic [31:0] s, bit pc, logic [31:0] ar,
                                             logic [1:0] k, bit ci);
      logic [31:0] o;
      logic [31:0] v;
      int n;
      int m;
      o = pc ? s + 32'd4 : s;
      n = int'(ar[7:0]);
      if (n == 0) return {ci, o};
      case (k)
         2'b00: begin
            if (n < 32) return {o[32-n], o << n};
            else if (n == 32) return {o[0], 32'd0};
            else return {1'b0, 32'd0};
         end
         2'b01: begin
            if (n < 32) return {o[n-1], o >> n};
            else if (n == 32) return {o[31], 32'd0};
            else return {1'b0, 32'd0};
         end
         2'b10: begin
            if (n < 32) return {o[n-1], 32'($signed(o) >>> n)};
            else return {o[31], {32{o[31]}}};
         end
         default: begin
            m = n % 32;
            if (m == 0) return {o[31], o};
            v = (o >> m) | (o << (32 - m));
            return {o[m-1], v};
         end
      endcase
   endfunction

   task automatic apply(logic [31:0] s, bit pc, logic [31:0] ar, logic [1:0] k, bit ci);
      @(posedge clk);
      src_val    = s;
      src_is_pc  = pc;
      amt_reg    = ar;
      shift_kind = k;
      carry_in   = ci;
      @(negedge clk);
   endtask

   task automatic check(string tag, logic [31:0] exp_v, logic exp_c);
      n_checks++;
      if (shifted_val !== exp_v || carry_out !== exp_c) begin
         n_fails++;
         $display("FAIL %s: kind=%0d amt=%08h src=%08h pc=%0d got val=%08h c=%0b exp val=%08h c=%0b",
                  tag, shift_kind, amt_reg, src_val, src_is_pc, shifted_val, carry_out, exp_v, exp_c);
      end
   endtask

   function automatic string tag_for(logic [1:0] k, int n);
      if (n == 0) return "R4";
      case (k)
         2'b00: return (n < 32) ? "R5" : "R6";
         2'b01: return (n < 32) ? "R7" : "R8";
         2'b10: return (n < 32) ? "R9" : "R10";
         default: return (n % 32 != 0) ? "R11" : "R12";
      endcase
   endfunction

   task automatic t_idle;
      apply(32'd0, 1'b0, 32'd0, 2'b00, 1'b0);
      check("R13 idle inputs", 32'd0, 1'b0);
   endtask

   task automatic t_kind_encoding;
      apply(32'h8000_0001, 1'b0, 32'd1, 2'b00, 1'b0); check("R1 kind 00 LSL", 32'h0000_0002, 1'b1);
      apply(32'h8000_0001, 1'b0, 32'd1, 2'b01, 1'b0); check("R1 kind 01 LSR", 32'h4000_0000, 1'b1);
      apply(32'h8000_0001, 1'b0, 32'd1, 2'b10, 1'b0); check("R1 kind 10 ASR", 32'hC000_0000, 1'b1);
      apply(32'h8000_0001, 1'b0, 32'd1, 2'b11, 1'b0); check("R1 kind 11 ROR", 32'hC000_0000, 1'b1);
   endtask

   task automatic t_zero_amount;
      for (int k = 0; k < 4; k++) begin
         apply(32'hA5A5_0F0F, 1'b0, 32'd0, 2'(k), 1'b1);
         check("R4 zero amount cin=1", 32'hA5A5_0F0F, 1'b1);
         apply(32'hA5A5_0F0F, 1'b0, 32'h0000_0100, 2'(k), 1'b0);
         check("R4 low byte zero cin=0", 32'hA5A5_0F0F, 1'b0);
      end
   endtask

   task automatic t_lsl;
      apply(32'h0000_00FF, 1'b0, 32'd4, 2'b00, 1'b1);  check("R5 lsl 4", 32'h0000_0FF0, 1'b0);
      apply(32'h1000_0000, 1'b0, 32'd4, 2'b00, 1'b0);  check("R5 lsl carry", 32'h0000_0000, 1'b1);
      apply(32'h0000_0001, 1'b0, 32'd32, 2'b00, 1'b0); check("R6 lsl 32", 32'h0000_0000, 1'b1);
      apply(32'hFFFF_FFFF, 1'b0, 32'd33, 2'b00, 1'b1); check("R6 lsl 33", 32'h0000_0000, 1'b0);
   endtask

   task automatic t_lsr;
      apply(32'h0000_0F08, 1'b0, 32'd4, 2'b01, 1'b1);  check("R7 lsr 4", 32'h0000_00F0, 1'b1);
      apply(32'h8000_0000, 1'b0, 32'd31, 2'b01, 1'b1); check("R7 lsr 31", 32'h0000_0001, 1'b0);
      apply(32'h8000_0000, 1'b0, 32'd32, 2'b01, 1'b0); check("R8 lsr 32", 32'h0000_0000, 1'b1);
      apply(32'hFFFF_FFFF, 1'b0, 32'd255, 2'b01, 1'b1); check("R8 lsr 255", 32'h0000_0000, 1'b0);
   endtask

   task automatic t_asr;
      apply(32'h8000_0000, 1'b0, 32'd31, 2'b10, 1'b1); check("R9 asr 31", 32'hFFFF_FFFF, 1'b0);
      apply(32'h7000_0004, 1'b0, 32'd3, 2'b10, 1'b0);  check("R9 asr 3", 32'h0E00_0000, 1'b1);
      apply(32'h8000_0010, 1'b0, 32'd40, 2'b10, 1'b0); check("R10 asr 40 neg", 32'hFFFF_FFFF, 1'b1);
      apply(32'h7FFF_FFFF, 1'b0, 32'd200, 2'b10, 1'b1); check("R10 asr 200 pos", 32'h0000_0000, 1'b0);
   endtask

   task automatic t_ror;
      apply(32'h1234_5678, 1'b0, 32'd8, 2'b11, 1'b1);  check("R11 ror 8", 32'h7812_3456, 1'b0);
      apply(32'h1234_5678, 1'b0, 32'd36, 2'b11, 1'b0); check("R11 ror 36", 32'h8123_4567, 1'b1);
      apply(32'h8000_0000, 1'b0, 32'd64, 2'b11, 1'b0); check("R12 ror 64", 32'h8000_0000, 1'b1);
      apply(32'h7FFF_FFFF, 1'b0, 32'd32, 2'b11, 1'b1); check("R12 ror 32", 32'h7FFF_FFFF, 1'b0);
   endtask

   task automatic t_upper_ignored;
      apply(32'h0000_0003, 1'b0, 32'hFFFF_FF01, 2'b00, 1'b1); check("R2 upper bits lsl", 32'h0000_0006, 1'b0);
      apply(32'h8000_0000, 1'b0, 32'hABCD_0020, 2'b01, 1'b0); check("R2 upper bits lsr", 32'h0000_0000, 1'b1);
      apply(32'h1234_5678, 1'b0, 32'h8000_0000, 2'b11, 1'b1); check("R2 upper bits only", 32'h1234_5678, 1'b1);
   endtask

   task automatic t_pc;
      apply(32'hFFFF_FFFC, 1'b1, 32'd0, 2'b00, 1'b1); check("R3 pc wrap pass", 32'h0000_0000, 1'b1);
      apply(32'h0000_0010, 1'b1, 32'd1, 2'b01, 1'b1); check("R3 pc lsr", 32'h0000_000A, 1'b0);
      apply(32'h7FFF_FFFC, 1'b1, 32'd32, 2'b10, 1'b0); check("R3 pc asr 32", 32'hFFFF_FFFF, 1'b1);
      apply(32'h0000_0010, 1'b0, 32'd1, 2'b01, 1'b1); check("R3 non-pc lsr", 32'h0000_0008, 1'b0);
   endtask

   task automatic t_sweep;
      int amts[7] = '{0, 1, 31, 32, 33, 64, 255};
      logic [31:0] ops[3] = '{32'h8000_0001, 32'h7FFF_0FF0, 32'hFFFF_FFFC};
      logic [32:0] e;
      for (int k = 0; k < 4; k++)
         for (int a = 0; a < 7; a++)
            for (int p = 0; p < 2; p++)
               for (int o = 0; o < 3; o++)
                  for (int c = 0; c < 2; c++) begin
                     e = ref_model(ops[o], p[0], 32'(amts[a]) | 32'h5A00_0000, 2'(k), c[0]);
                     apply(ops[o], p[0], 32'(amts[a]) | 32'h5A00_0000, 2'(k), c[0]);
                     check(tag_for(2'(k), amts[a]), e[31:0], e[32]);
                  end
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      t_idle();
      t_kind_encoding();
      t_zero_amount();
      t_lsl();
      t_lsr();
      t_asr();
      t_ror();
      t_upper_ignored();
      t_pc();
      t_sweep();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete, got timeout exp completion");
         summary();
         $finish;
      end
   end
endmodule